// File: doc/BRIEF.md
# Per-Core Job Sequence Tracker

This block keeps the bookkeeping for work handed to a group of hashing cores. Every core can hold two jobs at once, one running and one queued behind it. Each accepted dispatch receives a tag from a shared counter that wraps within a power-of-two range. The block remembers, for every core, the tag of the most recent job sent to it.

Status reports come back tagged with a sequence number and carry two busy bits per core. A core's busy bits describe its real state only when the report has caught up with that core's last dispatch. Catching up means the report's sequence is equal to or ahead of the last tag in modular terms. When a report is current for a core, the core's in-flight count is rebuilt from its two busy bits. When it is stale, the count is left alone.

A dispatch to a core that already holds two jobs is refused and flagged with a one-cycle error pulse. The block also keeps a per-core flag that records whether both slots were seen busy. It reports how many of the chain's slots are still free, out of a target of two per core.

Top module: `seq_trk`

## Requirements
- R1: After reset every in-flight count, every seen-both-busy flag and every busy-current flag is 0, free_slots equals 2*NUM_CORES, no dispatch pulse is raised, and the first accepted dispatch receives tag 0.
- R2: An accepted dispatch raises disp_done for one cycle in the cycle after the beat. disp_tag then carries the tag assigned, the counter advances by one modulo 2^SEQ_LOG2, and the addressed core's in-flight count rises by one.
- R3: A dispatch whose core would hold two jobs after the same beat's status update is refused. disp_err pulses for one cycle in the cycle after the beat, and no count, flag or tag counter changes because of it.
- R4: A status beat is current for core c only if c has been dispatched since reset and (stat_seq - last_tag[c]) mod 2^SEQ_LOG2 is below 2^(SEQ_LOG2-1). Only the low SEQ_LOG2 bits of stat_seq are used.
- R5: A current status beat sets core c's in-flight count to the number of its busy bits that are set, and sets busy_current[c]. A stale beat leaves the count unchanged and clears busy_current[c]. An accepted dispatch to c also clears busy_current[c].
- R6: Core c's running-job busy bit is stat_busy[2c] and its queued-job bit is stat_busy[2c+1]. Its in-flight count is reported on inflight_cnt[2c+1:2c].
- R7: seen_all_busy[c] is set by a current status beat that shows both of c's bits set, and is cleared only by an accepted dispatch to c. The clear wins over a set in the same cycle.
- R8: free_slots always equals 2*NUM_CORES minus the sum of all in-flight counts.
- R9: When a status beat and a dispatch to the same core arrive together, the status is applied first and the dispatch is then judged against, and added to, the resulting count.
- R10: disp_ready and stat_ready are always high, so the block never applies back-pressure. A beat is taken in any cycle its valid is high, and nothing changes while valid is low.
- R11: Tags wrap from 2^SEQ_LOG2-1 to 0, and the trust rule of R4 keeps working across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch beat present |
| disp_ready | output | 1 | Dispatch accepted (always high) |
| disp_core | input | IDX_W | Target core of the dispatch |
| disp_done | output | 1 | Pulse: previous dispatch accepted |
| disp_tag | output | 16 | Tag given to the accepted dispatch |
| disp_err | output | 1 | Pulse: previous dispatch refused |
| stat_valid | input | 1 | Status beat present |
| stat_ready | output | 1 | Status accepted (always high) |
| stat_seq | input | 16 | Sequence number carried by the status |
| stat_busy | input | 2*NUM_CORES | Busy bits, two per core |
| inflight_cnt | output | 2*NUM_CORES | In-flight count per core, 2 bits each |
| busy_current | output | NUM_CORES | Last status was current for the core |
| seen_all_busy | output | NUM_CORES | Both slots seen busy since last dispatch |
| free_slots | output | CNT_W | Free slots out of 2*NUM_CORES |

## Verification
The assertions assume that disp_core and disp_valid are held low through reset, so the first sampled beat follows the reset release. They also assume that status sequence numbers never run more than half the range ahead of a core's last tag while jobs are outstanding. Under that assumption the modular comparison cannot alias. The stimulus drives every beat at the falling edge and clears it one cycle later. It keeps all outstanding tags within a few counts of one another and moves across the wrap only on a single core, with each job retired before the next one is sent.

// File: rtl/seq_trk_pkg.sv
package seq_trk_pkg;

  localparam int SEQ_PORT_W = 16;

  typedef struct packed {
    logic pend;
    logic act;
  } busy_pair_t;

  // Modular distance from rx up to tx within a range of size rng.
  function automatic logic [16:0] seq_dist(input logic [15:0] tx,
                                           input logic [15:0] rx,
                                           input logic [16:0] rng);
    logic [16:0] t17, r17;
    t17 = {1'b0, tx};
    r17 = {1'b0, rx};
    if (t17 >= r17) seq_dist = t17 - r17;
    else            seq_dist = rng + t17 - r17;
  endfunction

  function automatic logic [1:0] pair_count(input busy_pair_t p);
    pair_count = {1'b0, p.act} + {1'b0, p.pend};
  endfunction

endpackage

// File: rtl/seq_trk_counter.sv
module seq_trk_counter #(
  parameter int SEQ_LOG2 = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  output logic [SEQ_LOG2-1:0] cur
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cur <= '0;
    else if (adv) cur <= cur + SEQ_LOG2'(1);
  end
endmodule

// File: rtl/seq_trk_core.sv
module seq_trk_core
  import seq_trk_pkg::*;
#(
  parameter int SEQ_LOG2 = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stat_fire,
  input  logic [SEQ_LOG2-1:0] stat_seq,
  input  busy_pair_t          busy,
  input  logic                disp_hit,
  input  logic [SEQ_LOG2-1:0] tag_in,
  output logic                accept,
  output logic [1:0]          cnt,
  output logic                current,
  output logic                seen_all
);
  localparam logic [16:0] RANGE = 17'(1) << SEQ_LOG2;
  localparam logic [16:0] HALF  = RANGE >> 1;

  logic [SEQ_LOG2-1:0] last_q;
  logic                sent_q;
  logic [16:0]         fwd;
  logic                caught;
  logic                trust_now;
  logic [1:0]          base;

  always_comb begin
    fwd       = seq_dist(16'(stat_seq), 16'(last_q), RANGE);
    caught    = sent_q && (fwd < HALF);
    trust_now = stat_fire && caught;
    base      = trust_now ? pair_count(busy) : cnt;
    accept    = disp_hit && (base != 2'd2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q   <= '0;
      sent_q   <= 1'b0;
      cnt      <= 2'd0;
      current  <= 1'b0;
      seen_all <= 1'b0;
    end else begin
      cnt <= base + {1'b0, accept};
      if (accept) begin
        last_q   <= tag_in;
        sent_q   <= 1'b1;
        current  <= 1'b0;
        seen_all <= 1'b0;
      end else begin
        if (stat_fire) current <= caught;
        if (trust_now && busy.act && busy.pend) seen_all <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/seq_trk_total.sv
module seq_trk_total #(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 4
) (
  input  logic [2*NUM_CORES-1:0] cnts,
  output logic [CNT_W-1:0]       free_slots
);
  localparam int TARGET = 2 * NUM_CORES;

  logic [CNT_W-1:0] sum;

  always_comb begin
    sum = '0;
    for (int c = 0; c < NUM_CORES; c++)
      sum = sum + CNT_W'(cnts[2*c +: 2]);
    free_slots = CNT_W'(TARGET) - sum;
  end
endmodule

// File: rtl/seq_trk.sv
module seq_trk
  import seq_trk_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int SEQ_LOG2  = 8,
  localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int CNT_W    = $clog2(2 * NUM_CORES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   disp_valid,
  output logic                   disp_ready,
  input  logic [IDX_W-1:0]       disp_core,
  output logic                   disp_done,
  output logic [15:0]            disp_tag,
  output logic                   disp_err,
  input  logic                   stat_valid,
  output logic                   stat_ready,
  input  logic [15:0]            stat_seq,
  input  logic [2*NUM_CORES-1:0] stat_busy,
  output logic [2*NUM_CORES-1:0] inflight_cnt,
  output logic [NUM_CORES-1:0]   busy_current,
  output logic [NUM_CORES-1:0]   seen_all_busy,
  output logic [CNT_W-1:0]       free_slots
);
  logic [SEQ_LOG2-1:0]  tag_cur;
  logic [NUM_CORES-1:0] acc_vec;
  logic                 any_acc;
  logic                 disp_fire, stat_fire;

  assign disp_ready = 1'b1;
  assign stat_ready = 1'b1;
  assign disp_fire  = disp_valid && disp_ready;
  assign stat_fire  = stat_valid && stat_ready;
  assign any_acc    = |acc_vec;

  seq_trk_counter #(.SEQ_LOG2(SEQ_LOG2)) u_ctr (
    .clk(clk), .rst_n(rst_n), .adv(any_acc), .cur(tag_cur)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    busy_pair_t bp;
    logic       hit;
    assign bp.act  = stat_busy[2*c];
    assign bp.pend = stat_busy[2*c+1];
    assign hit     = disp_fire && (disp_core == IDX_W'(c));
    seq_trk_core #(.SEQ_LOG2(SEQ_LOG2)) u_core (
      .clk(clk), .rst_n(rst_n),
      .stat_fire(stat_fire), .stat_seq(stat_seq[SEQ_LOG2-1:0]),
      .busy(bp), .disp_hit(hit), .tag_in(tag_cur),
      .accept(acc_vec[c]), .cnt(inflight_cnt[2*c +: 2]),
      .current(busy_current[c]), .seen_all(seen_all_busy[c])
    );
  end

  seq_trk_total #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W)) u_total (
    .cnts(inflight_cnt), .free_slots(free_slots)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_done <= 1'b0;
      disp_err  <= 1'b0;
      disp_tag  <= '0;
    end else begin
      disp_done <= any_acc;
      disp_err  <= disp_fire && !any_acc;
      if (any_acc) disp_tag <= 16'(tag_cur);
    end
  end
endmodule

// File: rtl/seq_trk_chk.sv
module seq_trk_chk #(
  parameter int NUM_CORES = 4,
  parameter int SEQ_LOG2  = 8,
  parameter int IDX_W     = 2,
  parameter int CNT_W     = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   disp_valid,
  input logic [IDX_W-1:0]       disp_core,
  input logic                   disp_done,
  input logic [15:0]            disp_tag,
  input logic                   disp_err,
  input logic [2*NUM_CORES-1:0] inflight_cnt,
  input logic [NUM_CORES-1:0]   seen_all_busy,
  input logic [CNT_W-1:0]       free_slots
);
  logic [SEQ_LOG2-1:0] prev_tag;
  logic                have_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_tag <= '0;
      have_tag <= 1'b0;
    end else if (disp_done) begin
      prev_tag <= disp_tag[SEQ_LOG2-1:0];
      have_tag <= 1'b1;
    end
  end

  p_pulse_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_done && disp_err));

  p_pulse_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(disp_valid) |-> !disp_done && !disp_err);

  p_tag_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_done && have_tag) |-> disp_tag[SEQ_LOG2-1:0] == SEQ_LOG2'(prev_tag + 1'b1));

  p_free_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    free_slots <= CNT_W'(2 * NUM_CORES));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    p_cnt_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
      inflight_cnt[2*c +: 2] != 2'd3);
    p_seen_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_done && $past(disp_core) == IDX_W'(c)) |-> !seen_all_busy[c]);
  end
endmodule

bind seq_trk seq_trk_chk #(
  .NUM_CORES(NUM_CORES), .SEQ_LOG2(SEQ_LOG2), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_core(disp_core),
  .disp_done(disp_done), .disp_tag(disp_tag), .disp_err(disp_err),
  .inflight_cnt(inflight_cnt), .seen_all_busy(seen_all_busy),
  .free_slots(free_slots)
);

// File: tb/seq_trk_test.sv
module seq_trk_test;
  localparam int N = 4;
  localparam int L = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_valid = 1'b0;
  logic        disp_ready;
  logic [1:0]  disp_core = '0;
  logic        disp_done;
  logic [15:0] disp_tag;
  logic        disp_err;
  logic        stat_valid = 1'b0;
  logic        stat_ready;
  logic [15:0] stat_seq = '0;
  logic [7:0]  stat_busy = '0;
  logic [7:0]  inflight_cnt;
  logic [3:0]  busy_current;
  logic [3:0]  seen_all_busy;
  logic [3:0]  free_slots;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_tag = 0;

  always #10 clk = ~clk;

  seq_trk #(.NUM_CORES(N), .SEQ_LOG2(L)) uut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cnt_of(input int c);
    return int'(inflight_cnt[2*c +: 2]);
  endfunction

  task automatic dispatch(input int core, input bit ok);
    @(negedge clk);
    disp_valid = 1'b1; disp_core = 2'(core);
    @(negedge clk);
    disp_valid = 1'b0;
    check("R2 done", int'(disp_done), int'(ok));
    check("R3 err", int'(disp_err), int'(!ok));
    if (ok) begin
      check("R2/R11 tag", int'(disp_tag), exp_tag);
      exp_tag = (exp_tag + 1) % (1 << L);
    end
  endtask

  task automatic status(input int seq, input logic [7:0] busy);
    @(negedge clk);
    stat_valid = 1'b1; stat_seq = 16'(seq); stat_busy = busy;
    @(negedge clk);
    stat_valid = 1'b0; stat_busy = '0;
  endtask

  task automatic t_reset();
    check("R1 cnt", int'(inflight_cnt), 0);
    check("R1 seen", int'(seen_all_busy), 0);
    check("R1 current", int'(busy_current), 0);
    check("R1 free", int'(free_slots), 2 * N);
    check("R1 done", int'(disp_done), 0);
    check("R10 ready", int'(disp_ready && stat_ready), 1);
  endtask

  task automatic t_basic();
    dispatch(0, 1);
    check("R2 cnt0", cnt_of(0), 1);
    check("R8 free", int'(free_slots), 7);
    dispatch(1, 1);
    check("R6 cnt1", cnt_of(1), 1);
    status(1, 8'h00);
    check("R5 all zero", int'(inflight_cnt), 0);
    check("R4 current", int'(busy_current), 4'b0011);
  endtask

  task automatic t_stale_and_full();
    dispatch(1, 1);                       // tag 2
    status(1, 8'h00);                     // behind core1
    check("R4 stale hold", cnt_of(1), 1);
    check("R5 stale flag", int'(busy_current[1]), 0);
    status(2, 8'b0000_1100);
    check("R6 both busy", cnt_of(1), 2);
    check("R7 seen set", int'(seen_all_busy[1]), 1);
    check("R8 free", int'(free_slots), 6);
    dispatch(1, 0);
    check("R3 cnt kept", cnt_of(1), 2);
    dispatch(0, 1);                       // tag 3, refusal did not advance
    status(3, 8'b0000_0100);
    check("R5 one busy", cnt_of(1), 1);
    check("R7 seen kept", int'(seen_all_busy[1]), 1);
    check("R5 core0 idle", cnt_of(0), 0);
    dispatch(1, 1);                       // tag 4
    check("R7 seen clear", int'(seen_all_busy[1]), 0);
    check("R5 current clear", int'(busy_current[1]), 0);
    status(10, 8'h00);
    check("R4 ahead", int'(inflight_cnt), 0);
    dispatch(1, 1);                       // tag 5
    status(5 + 128, 8'h00);
    check("R4 half away", cnt_of(1), 1);
    status(5 + 127, 8'h00);
    check("R4 just inside", cnt_of(1), 0);
  endtask

  task automatic t_same_cycle();
    dispatch(2, 1);                       // tag 6
    @(negedge clk);
    stat_valid = 1'b1; stat_seq = 16'd6; stat_busy = 8'b0011_0000;
    disp_valid = 1'b1; disp_core = 2'd2;
    @(negedge clk);
    stat_valid = 1'b0; disp_valid = 1'b0; stat_busy = '0;
    check("R9 err", int'(disp_err), 1);
    check("R9 cnt", cnt_of(2), 2);
    check("R7 seen", int'(seen_all_busy[2]), 1);
    @(negedge clk);
    stat_valid = 1'b1; stat_seq = 16'd6; stat_busy = 8'b0010_0000;
    disp_valid = 1'b1; disp_core = 2'd2;
    @(negedge clk);
    stat_valid = 1'b0; disp_valid = 1'b0; stat_busy = '0;
    check("R9 done", int'(disp_done), 1);
    check("R9 tag", int'(disp_tag), exp_tag);
    exp_tag++;
    check("R9 cnt2", cnt_of(2), 2);
    check("R7 clear wins", int'(seen_all_busy[2]), 0);
    status(7, 8'h00);
    check("R8 drained", int'(free_slots), 8);
  endtask

  task automatic t_idle_inputs();
    @(negedge clk);
    stat_busy = 8'hFF; stat_seq = 16'd7; disp_core = 2'd3;
    repeat (3) @(negedge clk);
    check("R10 no pulse", int'(disp_done || disp_err), 0);
    check("R10 cnt", int'(inflight_cnt), 0);
    check("R10 seen", int'(seen_all_busy), 0);
    stat_busy = '0;
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 260; i++) begin
      int t;
      t = exp_tag;
      dispatch(0, 1);
      if (t == 0) begin
        status(255, 8'h00);
        check("R11 pre-wrap stale", cnt_of(0), 1);
      end
      status(t, 8'h00);
      if (t == 0) check("R11 wrap trusted", cnt_of(0), 0);
    end
    check("R11 final", cnt_of(0), 0);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
      end
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_stale_and_full();
        t_same_cycle();
        t_idle_inputs();
        t_wrap();
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule